// File: doc/BRIEF.md
# Byte-Register Target on a Two-Wire Serial Bus

This block answers as a target device on a two-wire serial bus with a fixed 7-bit address. It gives a master access to eight byte-wide registers that sit outside the block, such as the time and calendar registers of a clock. A fast system clock samples the bus clock line and the bus data line. Each line passes through a short synchronizer and a majority-vote filter. Edge logic then finds bus-clock edges and the START and STOP conditions.

Access goes through a 3-bit word pointer that advances by itself. In a write transaction, the first byte after the device address loads the pointer, and each following byte is stored at the pointer. A read may follow a pointer write after a repeated START. A read may also start on its own, and it then continues from wherever the pointer was left. The block drives the data line only by pulling it low, through an enable output. It reaches the register file through single-cycle read and write strobes that share one address output. A power-fail input stops all activity at once and returns the pointer to zero.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the device address (default 7'h68, so bytes 0xD0 for write and 0xD1 for read). Any other address gets no acknowledge, and every byte up to the next START or STOP is ignored, with no register write.
- R2: In a write transaction, the byte after the address byte loads its low three bits into the pointer. Each later byte is written at the pointer, and the pointer then advances by one. The block acknowledges each of these bytes.
- R3: The pointer is three bits wide and wraps from 7 to 0, for both writes and reads.
- R4: After a pointer write, a repeated START followed by the read address returns the register at the loaded pointer first, then the following registers, sent MSB first.
- R5: During a read, the pointer advances only when the master acknowledges a byte. After a not-acknowledge the block releases the data line and sends nothing more until the next START.
- R6: A read transaction with no pointer write starts at the pointer value left by the previous transaction.
- R7: While the power-fail input is high, any transaction in progress is dropped, the pointer is held at 0, the data line is released, no register strobe fires, and bus activity is ignored. Once power is good again, the block waits for a fresh START.
- R8: The block detects START (data falls while the bus clock is high) and STOP (data rises while the bus clock is high). A repeated START inside a transaction sends the block back to address reception.
- R9: A bus-clock pulse that lasts a single system-clock cycle is filtered out and does not count as a bit.
- R10: The data-line enable only pulls low. It changes only while the bus clock is low.
- R11: After reset the data line is released, both strobes are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrFail | input | 1 | High while supply is out of tolerance |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | High to pull the data line low (open-drain enable) |
| regAddr | output | 3 | Register index, equal to the word pointer |
| regWrEn | output | 1 | One-cycle write strobe for the register at regAddr |
| regWrData | output | 8 | Byte to be written with regWrEn |
| regRdEn | output | 1 | One-cycle strobe when the register at regAddr is captured |
| regRdData | input | 8 | Contents of the register at regAddr, combinational |

## Verification
The assertions assume that the master changes the bus clock and bus data only well apart from each other, by many system-clock cycles more than the filter delay. They also assume that the master never makes a START or STOP while the block holds the data line low, and that power-fail stays high for more than one cycle. The stimulus meets these by running the bus in quarter-periods of ten system cycles. The master changes data only in the middle of the clock-low phase, and power-fail is raised only while the bus clock is low. The one deliberate exception is the single-cycle clock glitch. It is placed in a clock-low phase with data steady, so even if it were not filtered it could not look like a START or STOP.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WORD,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic ptrClr;
    logic ptrLoad;
    logic ptrInc;
    logic shiftIn;
    logic shiftOut;
    logic txLoad;
    logic regWrite;
  } dpCmd_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  localparam int CW   = $clog2(VOTE_LEN + 1);
  localparam int HALF = VOTE_LEN / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [VOTE_LEN-1:0]    winQ;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_LEN; i++) ones = ones + CW'(winQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      winQ    <= '1;
      lineOut <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      winQ    <= {winQ[VOTE_LEN-2:0], syncQ[SYNC_STAGES-1]};
      lineOut <= (ones > CW'(HALF));
    end
  end

endmodule

// File: rtl/i2c_reg_dpath.sv
module i2c_reg_dpath
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] shiftByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [BYTE_W-1:0] regWrData
);

  logic [ADDR_W-1:0] ptrQ;
  logic [BYTE_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (cmd.ptrClr) begin
      ptrQ <= '0;
    end else if (cmd.ptrLoad) begin
      ptrQ <= shiftQ[ADDR_W-1:0];
    end else if (cmd.ptrInc) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
    end else if (cmd.txLoad) begin
      shiftQ <= regRdData;
    end else if (cmd.shiftIn) begin
      shiftQ <= {shiftQ[BYTE_W-2:0], sdaBit};
    end else if (cmd.shiftOut) begin
      shiftQ <= {shiftQ[BYTE_W-2:0], 1'b1};
    end
  end

  assign shiftByte = shiftQ;
  assign txBit     = shiftQ[BYTE_W-1];
  assign regAddr   = ptrQ;
  assign regWrEn   = cmd.regWrite;
  assign regRdEn   = cmd.txLoad;
  assign regWrData = shiftQ;

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic              txBit,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd,
  output logic              sdaDriveLow
);

  localparam logic [3:0] LAST = 4'(BYTE_W);

  busState_t stQ, stD;
  logic [3:0] bitQ, bitD;
  logic ackQ, ackD, rwQ, rwD, mAckQ, mAckD;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, rxState;

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign rxState  = (stQ == ST_ADDR) || (stQ == ST_WORD) || (stQ == ST_WRITE);

  always_comb begin
    stD   = stQ;
    bitD  = bitQ;
    ackD  = ackQ;
    rwD   = rwQ;
    mAckD = mAckQ;
    cmd   = '0;
    if (pwrFail) begin
      stD        = ST_IDLE;
      bitD       = '0;
      ackD       = 1'b0;
      cmd.ptrClr = 1'b1;
    end else if (startDet) begin
      stD  = ST_ADDR;
      bitD = '0;
      ackD = 1'b0;
    end else if (stopDet) begin
      stD  = ST_IDLE;
      bitD = '0;
      ackD = 1'b0;
    end else if (rxState) begin
      if (sclRise && !ackQ && bitQ != LAST) begin
        cmd.shiftIn = 1'b1;
        bitD        = bitQ + 1'b1;
      end else if (sclFall && !ackQ && bitQ == LAST) begin
        ackD = 1'b1;
        case (stQ)
          ST_ADDR: begin
            if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
              rwD = rxByte[0];
            end else begin
              ackD = 1'b0;
              stD  = ST_SKIP;
            end
          end
          ST_WORD: cmd.ptrLoad = 1'b1;
          default: begin
            cmd.regWrite = 1'b1;
            cmd.ptrInc   = 1'b1;
          end
        endcase
      end else if (sclFall && ackQ) begin
        ackD = 1'b0;
        bitD = '0;
        if (stQ == ST_ADDR) begin
          if (rwQ) begin
            stD        = ST_READ;
            cmd.txLoad = 1'b1;
          end else begin
            stD = ST_WORD;
          end
        end else begin
          stD = ST_WRITE;
        end
      end
    end else if (stQ == ST_READ) begin
      if (sclRise) begin
        if (!ackQ) begin
          if (bitQ != LAST) bitD = bitQ + 1'b1;
        end else begin
          mAckD      = ~sdaF;
          cmd.ptrInc = ~sdaF;
        end
      end else if (sclFall) begin
        if (!ackQ) begin
          if (bitQ == LAST) ackD = 1'b1;
          else cmd.shiftOut = 1'b1;
        end else begin
          ackD = 1'b0;
          bitD = '0;
          if (mAckQ) cmd.txLoad = 1'b1;
          else stD = ST_SKIP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      bitQ    <= '0;
      ackQ    <= 1'b0;
      rwQ     <= 1'b0;
      mAckQ   <= 1'b0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      stQ     <= stD;
      bitQ    <= bitD;
      ackQ    <= ackD;
      rwQ     <= rwD;
      mAckQ   <= mAckD;
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sdaDriveLow = (rxState && ackQ) || (stQ == ST_READ && !ackQ && !txBit);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         ADDR_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         VOTE_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, cleanLines;
  dpCmd_t            cmd;
  logic [BYTE_W-1:0] shiftByte;
  logic              txBit;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < NLINES; g++) begin : gFilt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_LEN   (VOTE_LEN)
    ) uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLines[g]),
      .lineOut(cleanLines[g])
    );
  end

  i2c_reg_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrFail    (pwrFail),
    .sclF       (cleanLines[0]),
    .sdaF       (cleanLines[1]),
    .txBit      (txBit),
    .rxByte     (shiftByte),
    .cmd        (cmd),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_reg_dpath #(
    .ADDR_W(ADDR_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sdaBit   (cleanLines[1]),
    .regRdData(regRdData),
    .shiftByte(shiftByte),
    .txBit    (txBit),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData)
  );

endmodule

// File: rtl/i2c_reg_chk.sv
module i2c_reg_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrFail,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr
);

  // R2: every register write is followed by a one-step pointer advance
  a_r2_write_advances: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == ADDR_W'($past(regAddr) + 1'b1));

  // R5: a read capture leaves the pointer where it was
  a_r5_read_keeps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> $stable(regAddr));

  // R5: read and write strobes never coincide
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdEn}));

  // R7: no register access while power is failing
  a_r7_no_strobe_in_fail: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> !regWrEn && !regRdEn);

  // R7: pointer returns to zero under power fail
  a_r7_ptr_cleared: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> regAddr == '0);

  // R7: data line released while power fail persists
  a_r7_line_released: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail && $past(pwrFail) |-> !sdaDriveLow);

  // R10: the pull-down enable moves only during the bus-clock low phase
  a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN || pwrFail)
    !$stable(sdaDriveLow) |-> !sclIn);

endmodule

bind i2c_reg_target i2c_reg_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pwrFail    (pwrFail),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;

  localparam int Q    = 10;
  localparam int WD   = 150000;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrFail = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaIn;
  logic sdaDriveLow;
  logic [2:0] regAddr;
  logic regWrEn, regRdEn;
  logic [7:0] regWrData, regRdData;

  logic [7:0] mem [NREG];
  logic [7:0] exp [NREG];
  int modelPtr = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sdaIn = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'hA0 + 8'(i);
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end

  i2c_reg_target u0 (
    .clk        (clk),
    .rstN       (rstN),
    .pwrFail    (pwrFail),
    .sclIn      (sclM),
    .sdaIn      (sdaIn),
    .sdaDriveLow(sdaDriveLow),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdEn    (regRdEn),
    .regRdData  (regRdData)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b0; waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic busRestart;
    sdaM = 1'b1; waitQ;
    sclM = 1'b1; waitQ;
    sdaM = 1'b0; waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ;
    sclM = 1'b1; waitQ;
    sdaM = 1'b1; waitQ;
    waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ;
      if (glitch && i == 7) begin
        sclM = 1'b1; @(negedge clk);
        sclM = 1'b0; waitQ;
      end
      sclM = 1'b1; waitQ; waitQ;
      sclM = 1'b0; waitQ;
    end
    sdaM = 1'b1; waitQ;
    sclM = 1'b1; waitQ;
    acked = (sdaIn == 1'b0);
    waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ;
      sclM = 1'b1; waitQ;
      b[i] = sdaIn;
      waitQ;
      sclM = 1'b0;
    end
    waitQ;
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ;
    sclM = 1'b1; waitQ; waitQ;
    sclM = 1'b0; waitQ;
    sdaM = 1'b1;
  endtask

  task automatic checkMem(input string req);
    for (int i = 0; i < NREG; i++) check(req, int'(mem[i]), int'(exp[i]));
  endtask

  // write n bytes starting at ptr; R2 and R3 expectations computed here
  task automatic xferWrite(input int ptr, input int n, input logic [7:0] base);
    bit a;
    logic [7:0] d;
    busStart;
    sendByte(8'hD0, 1'b0, a); check("R1 write address ack", int'(a), 1);
    sendByte(8'(ptr), 1'b0, a); check("R2 pointer byte ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      d = base + 8'(k * 8'h11);
      sendByte(d, 1'b0, a); check("R2 data byte ack", int'(a), 1);
      exp[(ptr + k) % NREG] = d;
    end
    busStop;
    modelPtr = (ptr + n) % NREG;
    check("R2 R3 pointer after write", int'(regAddr), modelPtr);
    checkMem("R2 R3 register contents");
  endtask

  // read n bytes; setPtr selects combined (R4) or pointer-retaining (R6)
  task automatic xferRead(input bit setPtr, input int ptr, input int n);
    bit a;
    logic [7:0] d;
    int p;
    busStart;
    if (setPtr) begin
      sendByte(8'hD0, 1'b0, a); check("R4 write address ack", int'(a), 1);
      sendByte(8'(ptr), 1'b0, a); check("R4 pointer ack", int'(a), 1);
      busRestart;
      p = ptr % NREG;
    end else begin
      p = modelPtr;
    end
    sendByte(8'hD1, 1'b0, a); check("R1 read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, d);
      if (setPtr) check("R4 combined read data", int'(d), int'(exp[(p + k) % NREG]));
      else check("R6 resumed read data", int'(d), int'(exp[(p + k) % NREG]));
    end
    check("R5 line released after nack", int'(sdaDriveLow), 0);
    busStop;
    modelPtr = (p + n - 1) % NREG;
    check("R5 pointer advances on master ack only", int'(regAddr), modelPtr);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) exp[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 line released in reset", int'(sdaDriveLow), 0);
    check("R11 no write strobe in reset", int'(regWrEn), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 pointer zero", int'(regAddr), 0);
    check("R11 no read strobe", int'(regRdEn), 0);

    // sweep of all start pointers: write, combined read, resumed read (R2 R3 R4 R5 R6)
    for (int p = 0; p < NREG; p++) begin
      xferWrite(p, 3, 8'(8'h10 * p + 1));
      xferRead(1'b1, p, 3);
      xferRead(1'b0, 0, 2);
    end

    // R1: foreign addresses are ignored
    busStart;
    sendByte(8'hA0, 1'b0, a); check("R1 foreign address not acked", int'(a), 0);
    sendByte(8'h05, 1'b0, a); check("R1 byte after foreign address", int'(a), 0);
    sendByte(8'hEE, 1'b0, a); check("R1 second byte ignored", int'(a), 0);
    busStop;
    busStart;
    sendByte(8'hD3, 1'b0, a); check("R1 near-miss address not acked", int'(a), 0);
    busStop;
    checkMem("R1 nothing written");
    check("R1 pointer untouched", int'(regAddr), modelPtr);

    // R8: repeated START inside a write
    busStart;
    sendByte(8'hD0, 1'b0, a); check("R8 address ack", int'(a), 1);
    sendByte(8'h01, 1'b0, a); check("R8 pointer ack", int'(a), 1);
    sendByte(8'h44, 1'b0, a); check("R8 data ack", int'(a), 1);
    exp[1] = 8'h44;
    busRestart;
    sendByte(8'hD0, 1'b0, a); check("R8 address after restart ack", int'(a), 1);
    sendByte(8'h05, 1'b0, a); check("R8 new pointer ack", int'(a), 1);
    sendByte(8'h66, 1'b0, a); check("R8 data after restart ack", int'(a), 1);
    exp[5] = 8'h66;
    busStop;
    modelPtr = 6;
    checkMem("R8 registers after restart");
    check("R8 pointer after restart", int'(regAddr), 6);

    // R9: single-cycle clock glitch is filtered
    busStart;
    sendByte(8'hD0, 1'b0, a); check("R9 address ack", int'(a), 1);
    sendByte(8'h03, 1'b1, a); check("R9 pointer ack with glitch", int'(a), 1);
    sendByte(8'h5A, 1'b1, a); check("R9 data ack with glitch", int'(a), 1);
    exp[3] = 8'h5A;
    busStop;
    modelPtr = 4;
    checkMem("R9 glitch did not shift bits");
    check("R9 pointer", int'(regAddr), 4);

    // R7: power fail aborts, clears pointer, ignores bus
    busStart;
    sendByte(8'hD0, 1'b0, a); check("R7 address ack", int'(a), 1);
    sendByte(8'h06, 1'b0, a); check("R7 pointer ack", int'(a), 1);
    pwrFail = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 pointer cleared", int'(regAddr), 0);
    sendByte(8'h99, 1'b0, a); check("R7 byte ignored during fail", int'(a), 0);
    check("R7 line released during fail", int'(sdaDriveLow), 0);
    pwrFail = 1'b0;
    repeat (3) @(negedge clk);
    sendByte(8'h77, 1'b0, a); check("R7 no ack without new START", int'(a), 0);
    busStop;
    modelPtr = 0;
    checkMem("R7 nothing written");
    check("R7 pointer still zero", int'(regAddr), 0);
    xferRead(1'b0, 0, 1);
    check("R7 resumed read from zero leaves pointer", int'(regAddr), 0);

    // R3: read crosses the wrap
    xferWrite(7, 0, 8'h00);
    xferRead(1'b0, 0, 3);
    check("R3 pointer wrapped during read", int'(regAddr), 1);

    done = 1'b1;
    summary;
    $finish;
  end

endmodule